// File: doc/BRIEF.md
# Window Comparator Interrupt Unit

This unit sits behind a multi-channel analog-to-digital converter sequencer. It watches the stream of freshly converted results, one result per `res_valid` cycle. Each result that comes from a channel enabled in the target mask is tested against one lower/upper window that all channels share. A mode input decides whether a result inside the window or a result outside it counts as a comparator event. The test is made on every single conversion, not once per scan.

Two sticky status flags are kept: one for comparator events and one for completed scans, the latter set by a one-cycle `scan_done` strobe from the sequencer. Software clears each flag by a write-1 strobe. Each flag has its own enable, which gates only the interrupt. The two gated sources are merged into one single-cycle interrupt pulse toward the CPU. Conversion timing and register decode live outside this unit. Software keeps the lower bound no greater than the upper bound.

Top module: `adc_window_irq`

## Requirements
- R1: After reset is released, `cmp_flag`, `scan_flag` and `irq_pulse` are 0.
- R2: With `cfg_inside`=0, a qualifying result with `res_data` < `cfg_lower` or `res_data` > `cfg_upper` is a comparator event. A result equal to either bound is not an event.
- R3: With `cfg_inside`=1, a qualifying result with `cfg_lower` <= `res_data` <= `cfg_upper` is a comparator event. Both bounds are inclusive.
- R4: A result qualifies only if its channel index `res_chan` (0 to 5) has its bit set in `cfg_target`, where bit i selects channel i. Results from unmarked channels, and indices 6 and 7, never cause an event.
- R5: Every `res_valid` cycle is evaluated on its own, and `cmp_flag` reads 1 from the cycle after the event. When `res_valid` is 0, `res_data` and `res_chan` have no effect.
- R6: A `scan_done` strobe sets `scan_flag` from the next cycle.
- R7: Each flag stays set until its clear strobe (`cmp_clr` or `scan_clr`), after which it reads 0 from the next cycle. If a set event and a clear arrive in the same cycle, the flag stays set.
- R8: Flags are set whatever their enable. `cmp_ien` and `scan_ien` only gate whether the event produces an interrupt.
- R9: `irq_pulse` is 1 for exactly the cycle after any enabled event. When comparator and scan events fall in the same cycle they yield a single pulse. Events in consecutive cycles give pulses in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | A new conversion result is present this cycle |
| res_chan | input | 3 | Channel index of the result |
| res_data | input | 10 | Converted value |
| scan_done | input | 1 | One-cycle strobe: a full scan finished |
| cfg_lower | input | 10 | Window lower bound |
| cfg_upper | input | 10 | Window upper bound |
| cfg_target | input | 6 | Per-channel compare enable mask |
| cfg_inside | input | 1 | 1: event inside window, 0: event outside window |
| cmp_ien | input | 1 | Comparator interrupt enable |
| scan_ien | input | 1 | Scan interrupt enable |
| cmp_clr | input | 1 | Write-1 clear strobe for the comparator flag |
| scan_clr | input | 1 | Write-1 clear strobe for the scan flag |
| cmp_flag | output | 1 | Sticky comparator status |
| scan_flag | output | 1 | Sticky scan status |
| irq_pulse | output | 1 | Single-cycle merged interrupt |

## Verification
The hardest cases to reach are collisions in a single cycle. One is a comparator event landing on the same edge as its own clear strobe. Another is a comparator event coinciding with a scan strobe while both enables are on. The stimulus forces each of them on purpose, with a flag already set or cleared just before, so that a flag held set or a doubled pulse shows up at the outputs. Exact-bound values in both modes, unmarked channels and the out-of-range indices 6 and 7 are walked deliberately, with a clear between steps so that each result is judged on its own.

// File: rtl/wcmp_pkg.sv
// Shared sizing constants for the window comparator unit.
// Assumes: a single result lane and at most eight channels.
package wcmp_pkg;
    parameter int WCMP_DATA_W = 10;
    parameter int WCMP_NUM_CH = 6;
endpackage

// File: rtl/wcmp_window.sv
// Window test: reports whether data satisfies the selected window mode.
// Assumes: lower <= upper (kept by software); purely combinational.
module wcmp_window #(
    parameter int DW = 10
) (
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] lower,
    input  logic [DW-1:0] upper,
    input  logic          inside_mode,
    output logic          hit
);
    logic in_win;

    // Inclusive range test, then mode picks inside or outside sense.
    always_comb begin
        in_win = (data >= lower) && (data <= upper);
        hit    = inside_mode ? in_win : !in_win;
    end
endmodule

// File: rtl/wcmp_target_gate.sv
// Target gate: decides if the current result comes from a marked channel.
// Assumes: indices at or above NCH never match any mask bit.
module wcmp_target_gate #(
    parameter int NCH = 6,
    parameter int CW  = 3
) (
    input  logic           valid,
    input  logic [CW-1:0]  chan,
    input  logic [NCH-1:0] target,
    output logic           qualify
);
    logic [NCH-1:0] match;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // One decoder slot per channel.
        always_comb match[i] = valid && (chan == CW'(i)) && target[i];
    end

    // Any matching slot qualifies the result.
    always_comb qualify = |match;
endmodule

// File: rtl/wcmp_flag.sv
// Sticky status bit with write-1 clear; a set in the clear cycle wins.
// Assumes: synchronous active-low reset.
module wcmp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold, clear or set the status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= set | (flag & ~clr);
    end
endmodule

// File: rtl/adc_window_irq.sv
// Window comparator interrupt unit: per-result window check on marked
// channels, sticky comparator and scan flags, one merged interrupt pulse.
// Assumes: scan_done is a one-cycle strobe; lower <= upper.
module adc_window_irq #(
    parameter int NUM_CH = wcmp_pkg::WCMP_NUM_CH,
    parameter int DATA_W = wcmp_pkg::WCMP_DATA_W,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [DATA_W-1:0] res_data,
    input  logic              scan_done,
    input  logic [DATA_W-1:0] cfg_lower,
    input  logic [DATA_W-1:0] cfg_upper,
    input  logic [NUM_CH-1:0] cfg_target,
    input  logic              cfg_inside,
    input  logic              cmp_ien,
    input  logic              scan_ien,
    input  logic              cmp_clr,
    input  logic              scan_clr,
    output logic              cmp_flag,
    output logic              scan_flag,
    output logic              irq_pulse
);
    logic qualify;
    logic win_hit;
    logic cmp_event;
    logic irq_next;

    wcmp_target_gate #(.NCH(NUM_CH), .CW(CH_W)) u_gate (
        .valid   (res_valid),
        .chan    (res_chan),
        .target  (cfg_target),
        .qualify (qualify)
    );

    wcmp_window #(.DW(DATA_W)) u_win (
        .data        (res_data),
        .lower       (cfg_lower),
        .upper       (cfg_upper),
        .inside_mode (cfg_inside),
        .hit         (win_hit)
    );

    // A comparator event needs a qualified result that meets the window mode.
    always_comb cmp_event = qualify && win_hit;

    wcmp_flag u_cmp_flag (
        .clk (clk), .rst_n (rst_n),
        .set (cmp_event), .clr (cmp_clr), .flag (cmp_flag)
    );

    wcmp_flag u_scan_flag (
        .clk (clk), .rst_n (rst_n),
        .set (scan_done), .clr (scan_clr), .flag (scan_flag)
    );

    // Merge the enabled event sources into one request.
    always_comb irq_next = (cmp_event && cmp_ien) || (scan_done && scan_ien);

    // Register the request so the pulse lasts exactly one cycle per event cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= irq_next;
    end
endmodule

// File: rtl/adc_window_irq_chk.sv
// Checker for adc_window_irq: relates strobes and results to flags and pulse.
module adc_window_irq_chk #(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 10,
    parameter int CH_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [CH_W-1:0]   res_chan,
    input logic [DATA_W-1:0] res_data,
    input logic              scan_done,
    input logic [DATA_W-1:0] cfg_lower,
    input logic [DATA_W-1:0] cfg_upper,
    input logic [NUM_CH-1:0] cfg_target,
    input logic              cfg_inside,
    input logic              cmp_ien,
    input logic              scan_ien,
    input logic              cmp_clr,
    input logic              scan_clr,
    input logic              cmp_flag,
    input logic              scan_flag,
    input logic              irq_pulse
);
    logic [NUM_CH-1:0] tgt_shift;
    logic tgt_on;
    logic in_range;

    always_comb begin
        tgt_shift = cfg_target >> res_chan;
        tgt_on    = res_valid && tgt_shift[0];
        in_range  = (res_data >= cfg_lower) && (res_data <= cfg_upper);
    end

    // R3
    inside_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_on && cfg_inside && in_range |=> cmp_flag);

    // R2
    outside_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_on && !cfg_inside && !in_range |=> cmp_flag);

    // R4
    untargeted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !tgt_shift[0] && !cmp_flag |=> !cmp_flag);

    // R6
    scan_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> scan_flag);

    // R7
    scan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_clr && !scan_done |=> !scan_flag);

    // R8
    scan_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done && scan_ien |=> irq_pulse);

    // R9
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(cmp_ien) || $past(scan_done && scan_ien));

    // R9
    pulse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid && !scan_done |=> !irq_pulse);
endmodule

bind adc_window_irq adc_window_irq_chk #(
    .NUM_CH (NUM_CH), .DATA_W (DATA_W), .CH_W (CH_W)
) u_chk (.*);

// File: tb/adc_window_irq_bench.sv
// Scoreboard bench: driver applies one cycle and queues expected outputs,
// monitor pops and compares just after the capturing edge.
module adc_window_irq_bench;
    typedef struct {
        logic  c_flag;
        logic  s_flag;
        logic  irq;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_valid = 1'b0;
    logic [2:0] res_chan = '0;
    logic [9:0] res_data = '0;
    logic scan_done = 1'b0;
    logic [9:0] cfg_lower = 10'd100;
    logic [9:0] cfg_upper = 10'd200;
    logic [5:0] cfg_target = 6'h3F;
    logic cfg_inside = 1'b0;
    logic cmp_ien = 1'b1;
    logic scan_ien = 1'b1;
    logic cmp_clr = 1'b0;
    logic scan_clr = 1'b0;
    logic cmp_flag, scan_flag, irq_pulse;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic m_cmp = 0, m_scan = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    adc_window_irq u_adc_window_irq (.*);

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // One stimulus cycle plus its expected outcome on the next edge.
    task automatic drive(input logic v, input logic [2:0] ch, input logic [9:0] d,
                         input logic sd, input logic cc, input logic sc, input string tag);
        logic tgt, hit, ev;
        exp_t e;
        @(negedge clk);
        res_valid = v; res_chan = ch; res_data = d;
        scan_done = sd; cmp_clr = cc; scan_clr = sc;
        tgt = v && (ch < 3'd6) && cfg_target[ch];
        hit = cfg_inside ? (d >= cfg_lower && d <= cfg_upper)
                         : (d < cfg_lower || d > cfg_upper);
        ev = tgt && hit;
        m_cmp  = ev | (m_cmp & ~cc);
        m_scan = sd | (m_scan & ~sc);
        e.c_flag = m_cmp; e.s_flag = m_scan;
        e.irq = (ev && cmp_ien) || (sd && scan_ien);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic clr_all(input string tag);
        drive(1'b0, 3'd0, 10'd0, 1'b0, 1'b1, 1'b1, tag);
    endtask

    // Monitor: compare just after each capturing edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check1(e.tag, "cmp_flag", cmp_flag, e.c_flag);
            check1(e.tag, "scan_flag", scan_flag, e.s_flag);
            check1(e.tag, "irq_pulse", irq_pulse, e.irq);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check1("R1", "cmp_flag", cmp_flag, 1'b0);
        check1("R1", "scan_flag", scan_flag, 1'b0);
        check1("R1", "irq_pulse", irq_pulse, 1'b0);

        // R2: outside mode with exact bounds
        cfg_inside = 1'b0;
        drive(1, 3'd0, 10'd150, 0, 0, 0, "R2");
        drive(1, 3'd0, 10'd99, 0, 0, 0, "R2");
        clr_all("R7");
        drive(1, 3'd1, 10'd100, 0, 0, 0, "R2");
        drive(1, 3'd1, 10'd200, 0, 0, 0, "R2");
        drive(1, 3'd5, 10'd201, 0, 0, 0, "R2");
        clr_all("R7");
        // R3: inside mode with exact bounds
        cfg_inside = 1'b1;
        drive(1, 3'd2, 10'd100, 0, 0, 0, "R3");
        clr_all("R7");
        drive(1, 3'd2, 10'd99, 0, 0, 0, "R3");
        drive(1, 3'd3, 10'd201, 0, 0, 0, "R3");
        drive(1, 3'd3, 10'd200, 0, 0, 0, "R3");
        clr_all("R7");
        // R4: mask and out-of-range indices
        cfg_inside = 1'b0;
        cfg_target = 6'b000100;
        drive(1, 3'd0, 10'd10, 0, 0, 0, "R4");
        drive(1, 3'd5, 10'd900, 0, 0, 0, "R4");
        drive(1, 3'd2, 10'd10, 0, 0, 0, "R4");
        clr_all("R7");
        cfg_target = 6'h3F;
        drive(1, 3'd6, 10'd10, 0, 0, 0, "R4");
        drive(1, 3'd7, 10'd1000, 0, 0, 0, "R4");
        // R5: invalid data ignored, back-to-back results each judged
        drive(0, 3'd0, 10'd5, 0, 0, 0, "R5");
        drive(1, 3'd0, 10'd150, 0, 0, 0, "R5");
        drive(1, 3'd1, 10'd5, 0, 0, 0, "R5");
        drive(1, 3'd1, 10'd999, 0, 0, 0, "R9");
        idle("R9");
        // R7: set wins over clear on the same cycle
        drive(1, 3'd0, 10'd5, 0, 1, 0, "R7");
        drive(0, 3'd0, 10'd0, 1, 0, 1, "R7");
        clr_all("R7");
        // R6: scan strobe
        drive(0, 3'd0, 10'd0, 1, 0, 0, "R6");
        idle("R6");
        clr_all("R7");
        // R8: flags without enables
        cmp_ien = 0; scan_ien = 0;
        drive(1, 3'd4, 10'd3, 1, 0, 0, "R8");
        idle("R8");
        clr_all("R7");
        // R9: combined events, one pulse
        cmp_ien = 1; scan_ien = 1;
        drive(1, 3'd4, 10'd3, 1, 0, 0, "R9");
        idle("R9");
        cmp_ien = 1; scan_ien = 0;
        drive(0, 3'd0, 10'd0, 1, 1, 0, "R8");
        idle("R8");
        repeat (2) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule